// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Product Shifter

This block multiplies two 16-bit operands into a 32-bit product in one clock and feeds that product, after an optional justification shift, into a 32-bit accumulator. One operand sits in a temporary operand register that is written by its own load strobe. The other operand arrives on the same cycle as the multiply strobe, together with a flag that selects signed (two's complement) or unsigned operation. The product is kept in a product register.

A 2-bit mode input selects the shift applied at the product register's output. The shift can left-justify a fractional result: one position removes the duplicate sign bit of a signed 16×16 product, and four positions suit a second operand of 13 bits or fewer. An arithmetic right shift of six positions leaves headroom for long runs of accumulation. A MAC strobe adds the shifted product to the accumulator. A multiply issued in the same cycle refills the product register, so a new product can be formed every cycle while the previous one is summed. A clear strobe zeroes both the accumulator and the product register, which starts a fresh sum of products.

Top module: `mac_unit`

## Requirements
- R1: After reset the operand register, the product register and the accumulator are all zero.
- R2: A load strobe writes loadData into the operand register at the next clock edge. A multiply in the same cycle uses the value the register held before that edge.
- R3: With unsignedMode low, a multiply strobe writes the 32-bit two's-complement product of the operand register and mulOperand into the product register at the next edge.
- R4: With unsignedMode high, both operands are treated as unsigned and the full 32-bit unsigned product is stored.
- R5: shiftedP follows pReg through the mode code: 2'b00 passes it unchanged, 2'b01 shifts it left by 1, 2'b10 shifts it left by 4 (zero fill, truncated to 32 bits), and 2'b11 shifts it right by 6 with sign extension.
- R6: A MAC strobe adds to the accumulator the shifted product as it stood before the edge. A multiply in the same cycle loads the new product into the product register at that edge.
- R7: A clear strobe zeroes the accumulator and the product register at the next edge. It takes precedence over a multiply or MAC strobe in the same cycle and leaves the operand register unchanged.
- R8: With no multiply or clear strobe the product register holds its value. With no MAC or clear strobe the accumulator holds its value.
- R9: In mode 2'b11, 128 consecutive accumulations of the largest-magnitude negative product (-32768 × 32767) give exactly 128 times the shifted product, 32'h80010000, with no sign wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Write loadData into the operand register |
| loadData | input | 16 | Operand register data |
| mulStrobe | input | 1 | Multiply the operand register by mulOperand |
| mulOperand | input | 16 | Second multiplier operand |
| unsignedMode | input | 1 | 1 = unsigned multiply, 0 = signed |
| macStrobe | input | 1 | Add shiftedP to the accumulator |
| clearStrobe | input | 1 | Zero the accumulator and the product register |
| prodMode | input | 2 | Product shift mode |
| tReg | output | 16 | Operand register |
| pReg | output | 32 | Product register |
| shiftedP | output | 32 | Product after the mode shift |
| acc | output | 32 | Accumulator |

## Verification
Operand pairs cover small positives, mixed signs, a negative times -1, and the extremes 0x8000 and 0x7FFF. Each pair is run in both signed and unsigned mode, so a missing sign extension shows up as a wrong upper half. Every mode code is paired with products whose shifted value tells the modes apart: for example, 0xFFFE0001 shifted right exposes a logical shift where an arithmetic one is required, and 2^30 shifted left by 4 exposes missing truncation. Directed sequences cover:
- a MAC issued together with a multiply, to confirm the accumulator sums the older product;
- a clear issued together with MAC and multiply, to confirm clear wins;
- a load issued together with a multiply, to confirm the old operand is used;
- a 128-step accumulation at the edge of the headroom.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_LEFT1 = 2'b01,
    MODE_LEFT4 = 2'b10,
    MODE_RIGHT6 = 2'b11
  } prodModeT;

  typedef struct packed {
    logic loadT;
    logic mulEn;
    logic mulUnsigned;
    logic macEn;
    logic clrEn;
  } strobeT;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic   loadStrobe,
  input  logic   mulStrobe,
  input  logic   unsignedMode,
  input  logic   macStrobe,
  input  logic   clearStrobe,
  output strobeT strobes
);
  // Clear overrides the multiply and accumulate paths; operand load is independent.
  always_comb begin
    strobes.loadT       = loadStrobe;
    strobes.clrEn       = clearStrobe;
    strobes.mulEn       = mulStrobe & ~clearStrobe;
    strobes.mulUnsigned = unsignedMode;
    strobes.macEn       = macStrobe & ~clearStrobe;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHIFT_A = 1,
  parameter int SHIFT_B = 4,
  parameter int SHIFT_C = 6,
  localparam int PROD_W = 2 * DATA_W,
  localparam int EXT_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] mulOperand,
  input  logic [1:0]        prodMode,
  output logic [DATA_W-1:0] tReg,
  output logic [PROD_W-1:0] pReg,
  output logic [PROD_W-1:0] shiftedP,
  output logic [PROD_W-1:0] acc
);
  logic signed [EXT_W-1:0]     extT;
  logic signed [EXT_W-1:0]     extOp;
  logic signed [2*EXT_W-1:0]   fullProd;
  logic [PROD_W-1:0]           prodNext;
  logic [PROD_W-1:0]           shiftOpts [4];

  // One extra bit per operand lets a single signed multiplier serve both modes.
  always_comb begin
    extT     = {(~strobes.mulUnsigned) & tReg[DATA_W-1], tReg};
    extOp    = {(~strobes.mulUnsigned) & mulOperand[DATA_W-1], mulOperand};
    fullProd = extT * extOp;
    prodNext = fullProd[PROD_W-1:0];
  end

  localparam int SHIFT_AMT [4] = '{0, SHIFT_A, SHIFT_B, SHIFT_C};

  for (genvar m = 0; m < 4; m++) begin : g_shift
    if (m == 3) begin : g_right
      assign shiftOpts[m] = $unsigned($signed(pReg) >>> SHIFT_AMT[m]);
    end else begin : g_left
      assign shiftOpts[m] = pReg << SHIFT_AMT[m];
    end
  end

  assign shiftedP = shiftOpts[prodMode];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg <= '0;
      pReg <= '0;
      acc  <= '0;
    end else begin
      if (strobes.loadT) tReg <= loadData;
      if (strobes.clrEn) begin
        pReg <= '0;
        acc  <= '0;
      end else begin
        if (strobes.mulEn) pReg <= prodNext;
        if (strobes.macEn) acc  <= acc + shiftedP;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  input  logic [15:0] loadData,
  input  logic        mulStrobe,
  input  logic [15:0] mulOperand,
  input  logic        unsignedMode,
  input  logic        macStrobe,
  input  logic        clearStrobe,
  input  logic [1:0]  prodMode,
  output logic [15:0] tReg,
  output logic [31:0] pReg,
  output logic [31:0] shiftedP,
  output logic [31:0] acc
);
  strobeT strobes;

  mac_ctrl u_ctrl (
    .loadStrobe  (loadStrobe),
    .mulStrobe   (mulStrobe),
    .unsignedMode(unsignedMode),
    .macStrobe   (macStrobe),
    .clearStrobe (clearStrobe),
    .strobes     (strobes)
  );

  mac_datapath #(.DATA_W(16)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadData  (loadData),
    .mulOperand(mulOperand),
    .prodMode  (prodMode),
    .tReg      (tReg),
    .pReg      (pReg),
    .shiftedP  (shiftedP),
    .acc       (acc)
  );
endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        loadStrobe,
  input logic [15:0] loadData,
  input logic        mulStrobe,
  input logic [15:0] mulOperand,
  input logic        unsignedMode,
  input logic        macStrobe,
  input logic        clearStrobe,
  input logic [15:0] tReg,
  input logic [31:0] pReg,
  input logic [31:0] shiftedP,
  input logic [31:0] acc
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> tReg == $past(loadData));

  p_unsigned_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mulStrobe && unsignedMode && !clearStrobe) |=>
      pReg == $past({16'h0, tReg} * {16'h0, mulOperand}));

  p_mac_r6: assert property (@(posedge clk) disable iff (!rstN)
    (macStrobe && !clearStrobe) |=> acc == $past(acc) + $past(shiftedP));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearStrobe |=> (acc == 32'h0 && pReg == 32'h0));

  p_clear_keeps_t_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clearStrobe && !loadStrobe) |=> $stable(tReg));

  p_phold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!mulStrobe && !clearStrobe) |=> $stable(pReg));

  p_acchold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!macStrobe && !clearStrobe) |=> $stable(acc));
endmodule

bind mac_unit mac_unit_checker u_chk (
  .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadData(loadData),
  .mulStrobe(mulStrobe), .mulOperand(mulOperand), .unsignedMode(unsignedMode),
  .macStrobe(macStrobe), .clearStrobe(clearStrobe), .tReg(tReg),
  .pReg(pReg), .shiftedP(shiftedP), .acc(acc)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [15:0] loadData = '0;
  logic        mulStrobe = 1'b0;
  logic [15:0] mulOperand = '0;
  logic        unsignedMode = 1'b0;
  logic        macStrobe = 1'b0;
  logic        clearStrobe = 1'b0;
  logic [1:0]  prodMode = 2'b00;
  logic [15:0] tReg;
  logic [31:0] pReg, shiftedP, acc;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadData(loadData),
    .mulStrobe(mulStrobe), .mulOperand(mulOperand), .unsignedMode(unsignedMode),
    .macStrobe(macStrobe), .clearStrobe(clearStrobe), .prodMode(prodMode),
    .tReg(tReg), .pReg(pReg), .shiftedP(shiftedP), .acc(acc)
  );

  // {operand reg, mulOperand, unsigned, mode, expected pReg, expected shiftedP}
  localparam int NVEC = 9;
  localparam logic [98:0] VECS [NVEC] = '{
    {16'h0003, 16'h0005, 1'b0, 2'b00, 32'h0000000F, 32'h0000000F},
    {16'hFFFE, 16'h0007, 1'b0, 2'b01, 32'hFFFFFFF2, 32'hFFFFFFE4},
    {16'hFFFE, 16'h0007, 1'b1, 2'b00, 32'h0006FFF2, 32'h0006FFF2},
    {16'h8000, 16'h8000, 1'b0, 2'b01, 32'h40000000, 32'h80000000},
    {16'h8000, 16'h8000, 1'b1, 2'b10, 32'h40000000, 32'h00000000},
    {16'h1234, 16'h0FFF, 1'b0, 2'b10, 32'h01232DCC, 32'h1232DCC0},
    {16'hFFFF, 16'h0040, 1'b0, 2'b11, 32'hFFFFFFC0, 32'hFFFFFFFF},
    {16'hFFFF, 16'hFFFF, 1'b1, 2'b11, 32'hFFFE0001, 32'hFFFFF800},
    {16'h7FFF, 16'h8000, 1'b0, 2'b11, 32'hC0008000, 32'hFF000200}
  };

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadT(input logic [15:0] v);
    loadStrobe = 1'b1; loadData = v;
    tick();
    loadStrobe = 1'b0;
  endtask

  task automatic mul(input logic [15:0] op, input logic uns);
    mulStrobe = 1'b1; mulOperand = op; unsignedMode = uns;
    tick();
    mulStrobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    logic [98:0] v;
    logic [31:0] savedP;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 tReg", {16'h0, tReg}, 32'h0);
    check("R1 pReg", pReg, 32'h0);
    check("R1 acc", acc, 32'h0);
    rstN = 1'b1;
    tick();

    // Vector table: R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      loadT(v[98:83]);
      check("R2 load", {16'h0, tReg}, {16'h0, v[98:83]});
      mul(v[82:67], v[66]);
      prodMode = v[65:64];
      #1;
      check(v[66] ? "R4 unsigned product" : "R3 signed product", pReg, v[63:32]);
      check("R5 shift mode", shiftedP, v[31:0]);
    end

    // R8 hold without strobes
    savedP = pReg;
    tick(); tick();
    check("R8 pReg hold", pReg, savedP);
    check("R8 acc hold", acc, 32'h0);

    // R2 load and multiply in the same cycle use the old operand
    loadT(16'h0002);
    loadStrobe = 1'b1; loadData = 16'h0009;
    mulStrobe = 1'b1; mulOperand = 16'h0003; unsignedMode = 1'b0;
    tick();
    loadStrobe = 1'b0; mulStrobe = 1'b0;
    check("R2 old operand used", pReg, 32'h00000006);
    check("R2 new operand loaded", {16'h0, tReg}, 32'h00000009);

    // R6 pipelined MAC: acc sums old product while P takes new one
    prodMode = 2'b00;
    loadT(16'h0002);
    mul(16'h0003, 1'b0);
    macStrobe = 1'b1; mulStrobe = 1'b1; mulOperand = 16'h000A;
    tick();
    mulStrobe = 1'b0;
    check("R6 acc uses old P", acc, 32'h00000006);
    check("R6 new P", pReg, 32'h00000014);
    tick();
    macStrobe = 1'b0;
    check("R6 second MAC", acc, 32'h0000001A);

    // R7 clear wins over MAC and multiply, operand register kept
    clearStrobe = 1'b1; macStrobe = 1'b1; mulStrobe = 1'b1; mulOperand = 16'h0005;
    tick();
    clearStrobe = 1'b0; macStrobe = 1'b0; mulStrobe = 1'b0;
    check("R7 acc cleared", acc, 32'h0);
    check("R7 P cleared", pReg, 32'h0);
    check("R7 tReg kept", {16'h0, tReg}, 32'h00000002);

    // R9 128 accumulations in mode 11
    loadT(16'h8000);
    mul(16'h7FFF, 1'b0);
    prodMode = 2'b11;
    macStrobe = 1'b1;
    for (int k = 0; k < 64; k++) tick();
    macStrobe = 1'b0;
    check("R9 half run", acc, 32'hC0008000);
    macStrobe = 1'b1;
    for (int k = 0; k < 64; k++) tick();
    macStrobe = 1'b0;
    check("R9 full run", acc, 32'h80010000);
    check("R9 sign kept", {31'h0, acc[31]}, 32'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule